// File: doc/BRIEF.md
# Dual-Identity I2C Slave Front End

This block is the bit-level slave side of a two-wire serial bus, for a chip that must look like two separate devices to the bus master: a port device and a memory device. Both answer on the same pair of wires. Their 7-bit addresses differ only in the most significant bit, and the six bits below it come from strap inputs. The block samples SCL and SDA in the system clock domain, cleans them, finds START and STOP conditions, shifts bytes in and out, and drives SDA low through a pull-down enable when it acknowledges or sends a zero bit.

The back-ends do not see bus bits. They see single-cycle byte events: addressed, byte written, byte taken for reading, and transaction stopped. Each event is tagged with the selected target. For reads, the back-end keeps the next byte on `rd_data_i` at all times. The block latches that byte when it starts to send it and reports the latch as a read event, so the back-end can move its pointer forward. The memory back-end can refuse new transactions by raising a busy input. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `dual_id_i2c_slave`

## Requirements
- R1: After reset, `sda_pd_o` is 0 and no event is raised until the bus addresses the block.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A STOP that ends a transaction the block acknowledged raises one event of kind 3 carrying the target of that transaction.
- R3: The first byte after START is seven address bits, MSB first, then the direction bit (1 = read, 0 = write). The address is accepted when bits 6..1 of the byte equal `strap_i[5:0]`. Bit 7 = 0 selects the port target (tag 0) and bit 7 = 1 selects the memory target (tag 1). On acceptance the block pulls SDA low for the ninth clock and raises an event of kind 0 whose data is the whole address byte.
- R4: If the address does not match, the block does not acknowledge. It raises no event, including at the STOP, and drives nothing until the next START.
- R5: While `mem_busy_i` is 1, a memory address is not acknowledged and is ignored as in R4. A port address is still accepted.
- R6: In a write, each data byte is acknowledged in its ninth clock and raises an event of kind 1 carrying the byte.
- R7: In a read, the block latches `rd_data_i` at the SCL fall that ends the address acknowledge, or a master acknowledge. It raises an event of kind 2 carrying that byte and shifts it out MSB first on SDA.
- R8: When the master acknowledges a read byte, the next byte is sent. When the master does not acknowledge, the block releases SDA and sends nothing more until the next START.
- R9: A START with no STOP before it restarts address reception and may select a different target or direction. It raises no STOP event.
- R10: A pulse on SCL or SDA lasting fewer than FILT_LEN/2 + 1 system clocks (two clocks at the default FILT_LEN = 5) is ignored: it neither adds a bit nor counts as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pd_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 6 | Low six address bits |
| mem_busy_i | input | 1 | Memory target cannot take a transaction |
| rd_data_i | input | 8 | Next byte to send in a read |
| ev_valid_o | output | 1 | One-cycle event strobe |
| ev_kind_o | output | 2 | 0 addressed, 1 byte written, 2 byte taken for read, 3 stopped |
| ev_tgt_o | output | 1 | 0 port target, 1 memory target |
| ev_data_o | output | 8 | Address byte, written byte or read byte |

## Verification
A pad transition takes two synchroniser stages, FILT_LEN/2 + 1 window stages for the majority to turn, and one filter register before the block acts on it. Events and `sda_pd_o` therefore change seven system clocks after the SCL edge that causes them at the default filter length. The bench holds every SCL phase for sixteen clocks, so it samples the acknowledge and read bits in the middle of SCL high, well after the data line has settled. Events are pushed into a queue in bus order as each byte is driven. A monitor takes them off the queue in order as they appear, so no check depends on the exact cycle of an event. An event that arrives when nothing is expected is also reported.

// File: rtl/dual_id_i2c_slave.sv
module dual_id_i2c_slave #(
  parameter int FILT_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  input  logic [5:0] strap_i,
  input  logic       mem_busy_i,
  input  logic [7:0] rd_data_i,
  output logic       ev_valid_o,
  output logic [1:0] ev_kind_o,
  output logic       ev_tgt_o,
  output logic [7:0] ev_data_o
);

  localparam logic [1:0] EV_ADDR = 2'd0;
  localparam logic [1:0] EV_WR   = 2'd1;
  localparam logic [1:0] EV_RD   = 2'd2;
  localparam logic [1:0] EV_STOP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WRX, S_WACK, S_TX, S_RACK} st_t;

  function automatic logic maj(input logic [FILT_LEN-1:0] w);
    int n;
    n = 0;
    for (int i = 0; i < FILT_LEN; i++) if (w[i]) n++;
    return n > FILT_LEN / 2;
  endfunction

  logic [1:0]          scl_sy, sda_sy;
  logic [FILT_LEN-1:0] scl_w, sda_w;
  logic                scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_w  <= '1; sda_w  <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_d  <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_w  <= {scl_w[FILT_LEN-2:0], scl_sy[1]};
      sda_w  <= {sda_w[FILT_LEN-2:0], sda_sy[1]};
      scl_f  <= maj(scl_w);
      sda_f  <= maj(sda_w);
      scl_d  <= scl_f;
      sda_d  <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       sel, tgt, mack;

  wire addr_ok = (sh[6:1] == strap_i) && !(sh[7] && mem_busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      sel <= 1'b0; tgt <= 1'b0; mack <= 1'b0;
      sda_pd_o <= 1'b0;
      ev_valid_o <= 1'b0; ev_kind_o <= EV_ADDR; ev_tgt_o <= 1'b0; ev_data_o <= '0;
    end else begin
      ev_valid_o <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; sel <= 1'b0; sda_pd_o <= 1'b0;
      end else if (stop_c) begin
        if (sel) begin
          ev_valid_o <= 1'b1; ev_kind_o <= EV_STOP; ev_tgt_o <= tgt; ev_data_o <= '0;
        end
        st <= S_IDLE; sel <= 1'b0; sda_pd_o <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_ADDR, S_WRX: begin sh <= {sh[6:0], sda_f}; cnt <= cnt + 4'd1; end
          S_TX:          cnt <= cnt + 4'd1;
          S_RACK:        mack <= ~sda_f;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          S_ADDR: if (cnt == 4'd8) begin
            if (addr_ok) begin
              st <= S_AACK; sel <= 1'b1; tgt <= sh[7]; sda_pd_o <= 1'b1;
              ev_valid_o <= 1'b1; ev_kind_o <= EV_ADDR; ev_tgt_o <= sh[7]; ev_data_o <= sh;
            end else begin
              st <= S_IDLE;
            end
          end
          S_AACK: begin
            cnt <= '0;
            if (sh[0]) begin
              st <= S_TX; tx <= rd_data_i; sda_pd_o <= ~rd_data_i[7];
              ev_valid_o <= 1'b1; ev_kind_o <= EV_RD; ev_tgt_o <= tgt; ev_data_o <= rd_data_i;
            end else begin
              st <= S_WRX; sda_pd_o <= 1'b0;
            end
          end
          S_WRX: if (cnt == 4'd8) begin
            st <= S_WACK; sda_pd_o <= 1'b1;
            ev_valid_o <= 1'b1; ev_kind_o <= EV_WR; ev_tgt_o <= tgt; ev_data_o <= sh;
          end
          S_WACK: begin st <= S_WRX; cnt <= '0; sda_pd_o <= 1'b0; end
          S_TX: if (cnt == 4'd8) begin
            st <= S_RACK; sda_pd_o <= 1'b0;
          end else begin
            tx <= {tx[6:0], 1'b0}; sda_pd_o <= ~tx[6];
          end
          S_RACK: begin
            cnt <= '0;
            if (mack) begin
              st <= S_TX; tx <= rd_data_i; sda_pd_o <= ~rd_data_i[7];
              ev_valid_o <= 1'b1; ev_kind_o <= EV_RD; ev_tgt_o <= tgt; ev_data_o <= rd_data_i;
            end else begin
              st <= S_IDLE; sda_pd_o <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dual_id_i2c_slave_chk.sv
module dual_id_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pd_o,
  input logic [5:0] strap_i,
  input logic       mem_busy_i,
  input logic [7:0] rd_data_i,
  input logic       ev_valid_o,
  input logic [1:0] ev_kind_o,
  input logic       ev_tgt_o,
  input logic [7:0] ev_data_o
);

  assert_reset_release_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !sda_pd_o && !ev_valid_o);

  assert_addr_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_kind_o == 2'd0) |-> (ev_data_o[6:1] == strap_i && ev_tgt_o == ev_data_o[7]));

  assert_addr_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_kind_o == 2'd0) |-> sda_pd_o);

  assert_mem_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_kind_o == 2'd0 && ev_tgt_o) |-> !$past(mem_busy_i));

  assert_write_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_kind_o == 2'd1) |-> sda_pd_o);

  assert_read_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_kind_o == 2'd2) |-> (sda_pd_o == !ev_data_o[7] && ev_data_o == $past(rd_data_i)));

endmodule

bind dual_id_i2c_slave dual_id_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pd_o(sda_pd_o), .strap_i(strap_i),
  .mem_busy_i(mem_busy_i), .rd_data_i(rd_data_i), .ev_valid_o(ev_valid_o),
  .ev_kind_o(ev_kind_o), .ev_tgt_o(ev_tgt_o), .ev_data_o(ev_data_o)
);

// File: tb/sim_dual_id_i2c_slave.sv
`timescale 1ns/1ps
module sim_dual_id_i2c_slave;

  localparam int Q = 16;
  localparam logic [5:0] STRAP = 6'b101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic mem_busy = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sda_pd, ev_valid, ev_tgt;
  logic [1:0] ev_kind;
  logic [7:0] ev_data;
  wire sda_bus = m_sda & ~sda_pd;

  always #2 clk = ~clk;

  dual_id_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_pd_o(sda_pd),
    .strap_i(STRAP), .mem_busy_i(mem_busy), .rd_data_i(rd_data),
    .ev_valid_o(ev_valid), .ev_kind_o(ev_kind), .ev_tgt_o(ev_tgt), .ev_data_o(ev_data)
  );

  typedef struct {logic [1:0] k; logic t; logic [7:0] d; string r;} ev_t;
  ev_t q[$];
  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic expect_ev(logic [1:0] k, logic t, logic [7:0] d, string r);
    ev_t e;
    e.k = k; e.t = t; e.d = d; e.r = r;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && ev_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected event actual=%0d/%0d/%0h expected=none", cur_req, ev_kind, ev_tgt, ev_data);
      end else begin
        ev_t e;
        e = q.pop_front();
        if (ev_kind !== e.k || ev_tgt !== e.t || ev_data !== e.d) begin
          errors++;
          $display("FAIL %s event actual=%0d/%0d/%0h expected=%0d/%0d/%0h",
                   e.r, ev_kind, ev_tgt, ev_data, e.k, e.t, e.d);
        end
      end
    end
  end

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(Q);
      if (glitch && i == 4) begin m_scl = 1'b0; wq(1); m_scl = 1'b1; end
      if (glitch && i == 2) begin m_sda = 1'b1; wq(1); m_sda = 1'b0; end
      wq(Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    ack = (sda_bus == 1'b0);
    wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = !mack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(1); m_sda = 1'b1; wq(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    wq(5);
    chk("R1", {30'd0, sda_pd, ev_valid}, 0);
    rst_n = 1'b1;
    wq(20);
    chk("R1", {30'd0, sda_pd, ev_valid}, 0);

    cur_req = "R3";
    i2c_start;
    expect_ev(2'd0, 1'b0, {1'b0, STRAP, 1'b0}, "R3");
    send_byte({1'b0, STRAP, 1'b0}, 0, a);
    chk("R3", a, 1);
    expect_ev(2'd1, 1'b0, 8'hA5, "R6");
    send_byte(8'hA5, 0, a);
    chk("R6", a, 1);
    expect_ev(2'd1, 1'b0, 8'h3C, "R6");
    send_byte(8'h3C, 0, a);
    chk("R6", a, 1);
    expect_ev(2'd3, 1'b0, 8'h00, "R2");
    i2c_stop;
    chk("R2", sda_pd, 0);

    cur_req = "R9";
    rd_data = 8'h96;
    i2c_start;
    expect_ev(2'd0, 1'b1, {1'b1, STRAP, 1'b0}, "R3");
    send_byte({1'b1, STRAP, 1'b0}, 0, a);
    chk("R3", a, 1);
    expect_ev(2'd1, 1'b1, 8'h10, "R6");
    send_byte(8'h10, 0, a);
    chk("R6", a, 1);
    i2c_start;
    expect_ev(2'd0, 1'b1, {1'b1, STRAP, 1'b1}, "R9");
    expect_ev(2'd2, 1'b1, 8'h96, "R7");
    send_byte({1'b1, STRAP, 1'b1}, 0, a);
    chk("R9", a, 1);
    rd_data = 8'h4B;
    cur_req = "R8";
    expect_ev(2'd2, 1'b1, 8'h4B, "R8");
    recv_byte(1, b);
    chk("R7", b, 8'h96);
    rd_data = 8'hEE;
    recv_byte(0, b);
    chk("R8", b, 8'h4B);
    wq(Q);
    chk("R8", sda_pd, 0);
    expect_ev(2'd3, 1'b1, 8'h00, "R2");
    i2c_stop;

    cur_req = "R4";
    i2c_start;
    send_byte({1'b0, STRAP ^ 6'b000100, 1'b0}, 0, a);
    chk("R4", a, 0);
    send_byte(8'h00, 0, a);
    chk("R4", a, 0);
    i2c_stop;
    chk("R4", q.size(), 0);

    cur_req = "R5";
    mem_busy = 1'b1;
    i2c_start;
    send_byte({1'b1, STRAP, 1'b1}, 0, a);
    chk("R5", a, 0);
    chk("R5", sda_pd, 0);
    i2c_stop;
    i2c_start;
    expect_ev(2'd0, 1'b0, {1'b0, STRAP, 1'b0}, "R5");
    send_byte({1'b0, STRAP, 1'b0}, 0, a);
    chk("R5", a, 1);
    expect_ev(2'd3, 1'b0, 8'h00, "R5");
    i2c_stop;
    mem_busy = 1'b0;

    cur_req = "R10";
    m_sda = 1'b0; wq(1); m_sda = 1'b1; wq(Q);
    i2c_start;
    expect_ev(2'd0, 1'b0, {1'b0, STRAP, 1'b0}, "R10");
    send_byte({1'b0, STRAP, 1'b0}, 0, a);
    expect_ev(2'd1, 1'b0, 8'h5A, "R10");
    send_byte(8'h5A, 1, a);
    chk("R10", a, 1);
    expect_ev(2'd3, 1'b0, 8'h00, "R10");
    i2c_stop;

    wq(4 * Q);
    chk("R2", q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule